// File: doc/BRIEF.md
# Serial-Loaded Control Register Bank

This block holds the control words of a transmitter-style chip and loads them over a three-wire serial link made of chip select, serial clock and serial data. While chip select is low, each rising serial-clock edge shifts one bit into a 24-bit frame. The first bit in is the most significant. When chip select returns high, the block reads the last four bits of the frame as a register address. It then writes the 20 data bits that came before them into one of five registers: a main divider word, a reference divider word, a configuration word, an operating-control word and a test word.

All serial inputs and both power-domain inputs pass through multi-flop synchronizers into the system clock domain, so the whole block runs on one clock. A frame is written only when it has exactly 24 bits and names a register that exists. Bit positions a register does not use always read as zero. Two power-domain controls drive the enable outputs:
- A shutdown input turns every enable off.
- A transmit-gate input turns the transmit-path enables off and leaves the enables for the IF synthesizer, the IF oscillator and the serial port running.

Neither control changes the stored register values.

Top module: `serial_cfg_bank`

## Requirements
- R1: A frame is taken while chip select is low, one bit per rising serial-clock edge, most significant bit first. Frame bits 23:4 are the data and bits 3:0 are the address.
- R2: No register changes while a frame is still being shifted in. The write happens only after chip select goes from low to high and is visible within 8 system clocks of that edge.
- R3: Address 0 selects the main divider, 1 the reference divider, 2 the configuration word, 3 the operating-control word and 4 the test word.
- R4: After reset the registers read main divider 0x01F40, reference divider 0x00064, configuration 0x00A05, operating control 0x00101 and test 0x00000.
- R5: A frame whose address is 5 to 15 is dropped, and every register keeps its value.
- R6: A frame that holds 23 bits, or 25 bits, when chip select rises is dropped, and every register keeps its value.
- R7: Unused bit positions always read as zero, whatever value was written to them. The used-bit masks are 0x3FFFF for the main divider, 0x07FFF for the reference divider, 0x00FFF for the configuration word, 0x003FF for the operating-control word and 0x0000F for the test word.
- R8: While shutdown is low (active), both enable groups are all zero within 4 system clocks. The register contents are kept, and they read back unchanged after shutdown is released.
- R9: While shutdown is high and transmit gate is low, the always-on group reads 3'b111 and the transmit group reads 3'b000. The always-on group is bit 0 IF synthesizer, bit 1 IF oscillator and bit 2 serial port. Frames are still written in this state.
- R10: While shutdown and transmit gate are both high, both enable groups read 3'b111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_n_i | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data |
| pwr_on_i | input | 1 | Shutdown control, low turns all enables off |
| tx_gate_i | input | 1 | Transmit gate, low turns transmit-path enables off |
| div_main_o | output | 20 | Main divider register |
| div_ref_o | output | 20 | Reference divider register |
| cfg_word_o | output | 20 | Configuration register |
| op_ctl_o | output | 20 | Operating-control register |
| test_word_o | output | 20 | Test register |
| en_keep_o | output | 3 | Always-on enables: IF synthesizer, IF oscillator, serial port |
| en_tx_o | output | 3 | Transmit-path enables: modulator, upconverter, driver |

## Verification
Each register is written with alternating patterns (0xA5A5A and 0x5A5A5), with all ones and with all zeros. Alternating patterns expose swapped or shifted bit order. All ones shows whether each unused-bit mask is applied. Distinct values per address show whether the address decode is mis-wired.

Frames with the same data but addresses 5, 9 and 15, or with 23 or 25 bits, separate the address check from the bit-count check. A 25-bit frame leaves the correct 24 bits in the shift register, so only the count can reject it.

A frame is also checked before chip select rises, which catches an early write. The power controls are stepped through shutdown, gated and running states, with register reads in each, to show the enables follow the controls and the stored values stay intact.

// File: rtl/scb_pkg.sv
package scb_pkg;
   localparam int unsigned SCB_DATA_W = 20;
   localparam int unsigned SCB_ADDR_W = 4;
   localparam int unsigned SCB_NREGS  = 5;
   localparam int unsigned SCB_NEN    = 3;

   // index = register address
   localparam logic [SCB_NREGS-1:0][SCB_DATA_W-1:0] SCB_RST = '{
      20'h00000,   // 4 test
      20'h00101,   // 3 operating control
      20'h00A05,   // 2 configuration
      20'h00064,   // 1 reference divider
      20'h01F40    // 0 main divider
   };

   localparam logic [SCB_NREGS-1:0][SCB_DATA_W-1:0] SCB_MASK = '{
      20'h0000F,
      20'h003FF,
      20'h00FFF,
      20'h07FFF,
      20'h3FFFF
   };
endpackage

// File: rtl/scb_sync.sv
module scb_sync #(
   parameter int unsigned         WIDTH   = 1,
   parameter int unsigned         STAGES  = 2,
   parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("scb_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= {STAGES{RST_VAL}};
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scb_shifter.sv
module scb_shifter #(
   parameter int unsigned DATA_W = 20,
   parameter int unsigned ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_s,
   input  logic              sck_s,
   input  logic              sdat_s,
   output logic              commit_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o
);
   localparam int unsigned FRAME_W = DATA_W + ADDR_W;
   localparam int unsigned CNT_MAX = FRAME_W + 1;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   logic               sel_n_d, sck_d;
   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   cnt_q;
   logic               sck_rise, sel_rise;

   assign sck_rise = sck_s & ~sck_d;
   assign sel_rise = sel_n_s & ~sel_n_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_n_d <= 1'b1;
         sck_d   <= 1'b0;
      end else begin
         sel_n_d <= sel_n_s;
         sck_d   <= sck_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q <= '0;
         cnt_q   <= '0;
      end else if (sel_n_d) begin
         cnt_q   <= '0;
      end else if (sck_rise && !sel_n_s) begin
         shreg_q <= {shreg_q[FRAME_W-2:0], sdat_s};
         if (cnt_q != CNT_W'(CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_o <= 1'b0;
         addr_o   <= '0;
         data_o   <= '0;
      end else begin
         commit_o <= sel_rise && (cnt_q == CNT_W'(FRAME_W));
         if (sel_rise) begin
            addr_o <= shreg_q[ADDR_W-1:0];
            data_o <= shreg_q[FRAME_W-1:ADDR_W];
         end
      end
   end

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(CNT_MAX)) else $error("bit counter overran");            // R6
   AST_COMMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> sel_n_d) else $error("write while frame open");             // R2
   AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o) else $error("write pulse too long");             // R2
endmodule

// File: rtl/scb_regfile.sv
module scb_regfile #(
   parameter int unsigned DATA_W = 20,
   parameter int unsigned ADDR_W = 4,
   parameter int unsigned NREGS  = 5,
   parameter logic [NREGS-1:0][DATA_W-1:0] RST_VALS = '0,
   parameter logic [NREGS-1:0][DATA_W-1:0] MASKS    = '1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         commit_i,
   input  logic [ADDR_W-1:0]            addr_i,
   input  logic [DATA_W-1:0]            data_i,
   output logic [NREGS-1:0][DATA_W-1:0] regs_o
);
   logic [NREGS-1:0] wr_sel;

   generate
      if (NREGS > (1 << ADDR_W)) begin : g_bad
         $error("scb_regfile: NREGS exceeds address space");
      end
      for (genvar g = 0; g < NREGS; g++) begin : g_reg
         assign wr_sel[g] = commit_i && (addr_i == ADDR_W'(g));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               regs_o[g] <= RST_VALS[g] & MASKS[g];
            end else if (wr_sel[g]) begin
               regs_o[g] <= data_i & MASKS[g];
            end
         end
         AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (regs_o[g] & ~MASKS[g]) == '0) else $error("unused bits set");    // R7
      end
   endgenerate

   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel)) else $error("several registers selected");           // R3
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> $stable(regs_o)) else $error("register moved without write"); // R2
endmodule

// File: rtl/scb_enables.sv
module scb_enables #(
   parameter int unsigned NEN = 3
) (
   input  logic           pwr_on_s,
   input  logic           tx_gate_s,
   output logic [NEN-1:0] en_keep_o,
   output logic [NEN-1:0] en_tx_o
);
   assign en_keep_o = {NEN{pwr_on_s}};
   assign en_tx_o   = {NEN{pwr_on_s & tx_gate_s}};
endmodule

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank
   import scb_pkg::*;
#(
   parameter int unsigned DATA_W      = SCB_DATA_W,
   parameter int unsigned ADDR_W      = SCB_ADDR_W,
   parameter int unsigned NREGS       = SCB_NREGS,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n_i,
   input  logic              sck_i,
   input  logic              sdat_i,
   input  logic              pwr_on_i,
   input  logic              tx_gate_i,
   output logic [DATA_W-1:0] div_main_o,
   output logic [DATA_W-1:0] div_ref_o,
   output logic [DATA_W-1:0] cfg_word_o,
   output logic [DATA_W-1:0] op_ctl_o,
   output logic [DATA_W-1:0] test_word_o,
   output logic [2:0]        en_keep_o,
   output logic [2:0]        en_tx_o
);
   generate
      if (DATA_W != SCB_DATA_W || NREGS != SCB_NREGS) begin : g_bad
         $error("serial_cfg_bank: width or count disagrees with reset tables");
      end
   endgenerate

   logic [4:0] raw_in, sync_out;
   logic       commit;
   logic [ADDR_W-1:0] addr;
   logic [DATA_W-1:0] data;
   logic [NREGS-1:0][DATA_W-1:0] regs;

   assign raw_in = {tx_gate_i, pwr_on_i, sdat_i, sck_i, sel_n_i};

   scb_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b00001)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_out)
   );

   scb_shifter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sel_n_s(sync_out[0]), .sck_s(sync_out[1]), .sdat_s(sync_out[2]),
      .commit_o(commit), .addr_o(addr), .data_o(data)
   );

   scb_regfile #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREGS(NREGS),
      .RST_VALS(SCB_RST), .MASKS(SCB_MASK)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .commit_i(commit),
      .addr_i(addr), .data_i(data), .regs_o(regs)
   );

   scb_enables #(.NEN(3)) u_en (
      .pwr_on_s(sync_out[3]), .tx_gate_s(sync_out[4]),
      .en_keep_o(en_keep_o), .en_tx_o(en_tx_o)
   );

   assign div_main_o  = regs[0];
   assign div_ref_o   = regs[1];
   assign cfg_word_o  = regs[2];
   assign op_ctl_o    = regs[3];
   assign test_word_o = regs[4];

   AST_TX_NEEDS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_tx_o != 3'b000) |-> (en_keep_o == 3'b111)) else $error("tx on, core off"); // R9
   AST_EN_GROUPS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({en_keep_o == 3'b000, en_keep_o == 3'b111}) &&
      (en_keep_o == 3'b000 || en_keep_o == 3'b111)) else $error("split group"); // R8
endmodule

// File: tb/serial_cfg_bank_tb.sv
module serial_cfg_bank_tb;
   localparam int TB_CLK = 10;
   localparam int HALF   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sel_n = 1'b1, sck = 1'b0, sdat = 1'b0, pwr_on = 1'b1, tx_gate = 1'b1;
   logic [19:0] div_main, div_ref, cfg_word, op_ctl, test_word;
   logic [2:0]  en_keep, en_tx;

   int n_run = 0;
   int n_fail = 0;
   logic [19:0] model [5];
   logic [19:0] mask  [5];

   always #(TB_CLK/2) clk = ~clk;

   serial_cfg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .sel_n_i(sel_n), .sck_i(sck), .sdat_i(sdat),
      .pwr_on_i(pwr_on), .tx_gate_i(tx_gate),
      .div_main_o(div_main), .div_ref_o(div_ref), .cfg_word_o(cfg_word),
      .op_ctl_o(op_ctl), .test_word_o(test_word),
      .en_keep_o(en_keep), .en_tx_o(en_tx)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
      end
   endtask

   function automatic logic [19:0] rd(input int idx);
      case (idx)
         0: rd = div_main;
         1: rd = div_ref;
         2: rd = cfg_word;
         3: rd = op_ctl;
         default: rd = test_word;
      endcase
   endfunction

   task automatic check_all(input string tag);
      for (int i = 0; i < 5; i++) check(tag, rd(i), model[i]);
   endtask

   task automatic shift_bits(input logic [31:0] val, input int nbits);
      sel_n = 1'b0;
      wait_clk(HALF);
      for (int i = nbits - 1; i >= 0; i--) begin
         sdat = val[i];
         wait_clk(HALF);
         sck = 1'b1;
         wait_clk(HALF);
         sck = 1'b0;
      end
      wait_clk(HALF);
   endtask

   task automatic close_frame();
      sel_n = 1'b1;
      wait_clk(8);
   endtask

   task automatic send(input logic [19:0] d, input logic [3:0] a, input int nbits);
      shift_bits({7'h5a, 1'b1, d, a}, nbits);
      close_frame();
   endtask

   task automatic t_reset();
      check("R4 main", div_main, 20'h01F40);
      check("R4 ref", div_ref, 20'h00064);
      check("R4 cfg", cfg_word, 20'h00A05);
      check("R4 opctl", op_ctl, 20'h00101);
      check("R4 test", test_word, 20'h00000);
      check("R10 keep", {17'd0, en_keep}, 20'h7);
      check("R10 tx", {17'd0, en_tx}, 20'h7);
   endtask

   task automatic t_write_each();
      logic [19:0] pat [4] = '{20'hA5A5A, 20'h5A5A5, 20'hFFFFF, 20'h00000};
      for (int p = 0; p < 4; p++) begin
         for (int a = 0; a < 5; a++) begin
            logic [19:0] d = pat[p] ^ (20'h01111 * a);
            send(d, 4'(a), 24);
            model[a] = d & mask[a];
            check("R1 R3 R7 write", rd(a), model[a]);
         end
      end
      check_all("R3 all");
   endtask

   task automatic t_no_early();
      shift_bits({8'h00, 20'h12345, 4'd1}, 24);
      check("R2 before close", div_ref, model[1]);
      close_frame();
      model[1] = 20'h12345 & mask[1];
      check("R2 after close", div_ref, model[1]);
   endtask

   task automatic t_dont_care();
      send(20'hFFFFF, 4'd4, 24);
      model[4] = 20'h0000F;
      check("R7 test mask", test_word, 20'h0000F);
      send(20'hFF0AB, 4'd2, 24);
      model[2] = 20'h000AB;
      check("R7 cfg mask", cfg_word, 20'h000AB);
   endtask

   task automatic t_bad_addr();
      send(20'h0BEEF, 4'd5, 24);
      check_all("R5 addr5");
      send(20'h0BEEF, 4'd9, 24);
      check_all("R5 addr9");
      send(20'h0BEEF, 4'd15, 24);
      check_all("R5 addr15");
   endtask

   task automatic t_bad_len();
      send(20'h0ABCD, 4'd0, 23);
      check_all("R6 short");
      send(20'h0ABCD, 4'd0, 25);
      check_all("R6 long");
      send(20'h0ABCD, 4'd0, 24);
      model[0] = 20'h0ABCD;
      check("R6 exact", div_main, 20'h0ABCD);
   endtask

   task automatic t_power();
      pwr_on = 1'b0;
      wait_clk(4);
      check("R8 keep off", {17'd0, en_keep}, 20'h0);
      check("R8 tx off", {17'd0, en_tx}, 20'h0);
      check_all("R8 kept");
      pwr_on = 1'b1;
      tx_gate = 1'b0;
      wait_clk(4);
      check_all("R8 after release");
      check("R9 keep on", {17'd0, en_keep}, 20'h7);
      check("R9 tx off", {17'd0, en_tx}, 20'h0);
      send(20'h00321, 4'd3, 24);
      model[3] = 20'h00321;
      check("R9 write gated", op_ctl, 20'h00321);
      tx_gate = 1'b1;
      wait_clk(4);
      check("R10 keep", {17'd0, en_keep}, 20'h7);
      check("R10 tx", {17'd0, en_tx}, 20'h7);
   endtask

   initial begin
      #(TB_CLK * 150000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      model = '{20'h01F40, 20'h00064, 20'h00A05, 20'h00101, 20'h00000};
      mask  = '{20'h3FFFF, 20'h07FFF, 20'h00FFF, 20'h003FF, 20'h0000F};
      wait_clk(3);
      rst_n = 1'b1;
      wait_clk(6);
      t_reset();
      t_write_each();
      t_no_early();
      t_dont_care();
      t_bad_addr();
      t_bad_len();
      t_power();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule